// File: doc/BRIEF.md
# FG Period Speed Discriminator

This block closes the digital half of a motor speed loop. The motor's frequency generator (FG) pulse arrives already synchronised to the reference clock. The block times the interval between consecutive rising FG edges in reference clock cycles and compares it with a fixed target of `TARGET_COUNT` clocks, which is 512 by default. From that comparison it produces an accelerate/decelerate decision and an active-low speed-lock flag. Only every other FG period is evaluated, so the decision is refreshed once per two FG cycles.

Alongside the period measurement, a divider counts the reference clock down by `TARGET_COUNT`. A phase/frequency comparator checks this divided reference against every FG rising edge. It emits "up" or "down" pulses whose length equals the gap between the two edges. Clearing `run` halts and clears everything and reports lock as lost. A stalled motor lets the period counter saturate, which reads as too slow and unlocked.

Top module: `fg_speed_discriminator`

## Requirements
- R1: The period is the number of clock edges between two successive sampled FG rises. After `run` rises, the first FG rise only arms the block, and the period it closes is discarded. After that, periods alternate between measured and skipped. A discarded or skipped period leaves `accel` and `lock_n` unchanged.
- R2: When a period is measured, `accel` becomes 1 if the period is greater than 512 and 0 if it is 512 or less. The update happens at the clock edge that samples the closing FG rise.
- R3: A measured period from 480 to 544 inclusive (512 ± 1/16) drives `lock_n` to 0. Any other measured period drives `lock_n` to 1.
- R4: While `rst_n` is low, the outputs go to `accel`=1, `lock_n`=1, `ph_up`=0 and `ph_dn`=0.
- R5: The period counter saturates at 1023. If 1022 clock edges pass after the last FG rise with no new rise, then on that 1022nd edge `accel` becomes 1 and `lock_n` becomes 1, whatever the measure/skip slot.
- R6: While `run` is low, the block drives `accel`=1, `lock_n`=1 and both phase outputs 0 from the next clock edge. It also returns to the unarmed state.
- R7: The divided reference is aligned to the arming FG rise and ticks every 512 clocks after it. If an FG rise comes P clocks after the arming rise with P < 512, `ph_dn` is high for 512−P clocks starting at that rise. If P > 512, `ph_up` is high for P−512 clocks starting at the reference tick. If P = 512, neither output pulses.
- R8: `ph_up` and `ph_dn` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (1 MHz class) |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Run enable; low clears and halts measurement |
| fg | input | 1 | Synchronised FG pulse level |
| accel | output | 1 | 1 = accelerate, 0 = decelerate |
| ph_up | output | 1 | Phase comparator: reference led the FG edge |
| ph_dn | output | 1 | Phase comparator: FG led the reference edge |
| lock_n | output | 1 | 0 while the speed is inside the lock window |

## Verification
`accel` and `lock_n` change at the same edge that samples the closing FG rise. The bench therefore drives `fg` on falling edges and reads those outputs on the falling edge right after that rise. Phase pulses become visible one clock after the earlier of the two edges. The bench counts them sample by sample over a window that ends just before the next FG rise, so the count equals the pulse width. The stall boundary is checked at the falling edges 1021 and 1022 clocks after the last rise: the flags must still hold at the first and must have dropped at the second.

// File: rtl/fsd_pkg.sv
// Package: shared types and helpers for the FG speed discriminator.
// Assumes: periods and targets fit in 32-bit unsigned arithmetic.
package fsd_pkg;

    // Which role the FG period now running will play when it closes.
    typedef enum logic {
        SLOT_SKIP    = 1'b0,
        SLOT_MEASURE = 1'b1
    } slot_e;

    // True when v lies within target +/- tol, bounds included.
    function automatic logic in_window(input int unsigned v,
                                       input int unsigned target,
                                       input int unsigned tol);
        return (v + tol >= target) && (v <= target + tol);
    endfunction

endpackage

// File: rtl/fsd_edge.sv
// Module: rising edge finder for the synchronised FG level.
// Assumes: fg is already synchronous to clk; one cycle of delay is fine.
module fsd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic fg,
    output logic rise
);
    logic fg_q;

    // Keep the previous FG sample.
    always_ff @(posedge clk) begin
        if (!rst_n) fg_q <= 1'b0;
        else        fg_q <= fg;
    end

    assign rise = fg && !fg_q;

endmodule

// File: rtl/fsd_period_meter.sv
// Module: counts clocks between FG rises and picks which periods to publish.
// Assumes: rise is a single-cycle strobe; run low clears all state.
// Publishes a sample on the closing rise of every measured period. It also
// publishes a forced saturated sample when the counter reaches its ceiling.
module fsd_period_meter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             rise,
    output logic             armed,
    output logic             meas_valid,
    output logic [CNT_W-1:0] meas_val
);
    import fsd_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_NEAR = CNT_MAX - CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    slot_e            slot;
    logic             stall_hit;
    logic             period_hit;

    // Period counter, arming flag and measure/skip alternation.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt   <= '0;
            armed <= 1'b0;
            slot  <= SLOT_SKIP;
        end else if (rise) begin
            cnt   <= CNT_ONE;
            armed <= 1'b1;
            if (armed) slot <= (slot == SLOT_SKIP) ? SLOT_MEASURE : SLOT_SKIP;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + CNT_ONE;
        end
    end

    // A sample is published on a measured closing rise or on reaching saturation.
    always_comb begin
        period_hit = rise && armed && (slot == SLOT_MEASURE);
        stall_hit  = !rise && (cnt == CNT_NEAR);
        meas_valid = run && (period_hit || stall_hit);
        meas_val   = rise ? cnt : CNT_MAX;
    end

    // Once saturated with no FG edge, the counter holds its ceiling.
    p_cnt_saturates_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (cnt == CNT_MAX) && !rise) |=> (cnt == CNT_MAX));

    // A rise while running always restarts the count at one.
    p_rise_restarts_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && rise) |=> (cnt == CNT_ONE) && armed);

endmodule

// File: rtl/fsd_speed_judge.sv
// Module: turns published period samples into the accelerate and lock flags.
// Assumes: meas_valid is a strobe and meas_val holds the period in clocks.
module fsd_speed_judge #(
    parameter int CNT_W        = 10,
    parameter int TARGET_COUNT = 512,
    parameter int LOCK_TOL     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             meas_valid,
    input  logic [CNT_W-1:0] meas_val,
    output logic             accel,
    output logic             lock_n
);
    import fsd_pkg::*;

    logic [31:0] val32;
    assign val32 = 32'(meas_val);

    // Register the speed decision on each published sample; stop forces unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            accel  <= 1'b1;
            lock_n <= 1'b1;
        end else if (meas_valid) begin
            accel  <= val32 > 32'(TARGET_COUNT);
            lock_n <= !in_window(val32, 32'(TARGET_COUNT), 32'(LOCK_TOL));
        end
    end

    // Between published samples the flags do not move.
    p_hold_between_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !meas_valid) |=> ($stable(accel) && $stable(lock_n)));

    // A stopped block reports lost lock and asks for acceleration.
    p_stop_unlocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (lock_n && accel));

endmodule

// File: rtl/fsd_phase_cmp.sv
// Module: reference divider plus edge-driven phase/frequency comparator.
// Assumes: the divider is aligned by the arming rise; armed comes from the meter.
// The up pulse starts at a reference tick, the down pulse at an FG rise, and
// whichever edge arrives second clears both.
module fsd_phase_cmp #(
    parameter int CNT_W        = 10,
    parameter int TARGET_COUNT = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic rise,
    input  logic armed,
    output logic ph_up,
    output logic ph_dn
);
    localparam logic [CNT_W-1:0] DIV_TOP = CNT_W'(TARGET_COUNT);
    localparam logic [CNT_W-1:0] DIV_ONE = CNT_W'(1);

    logic [CNT_W-1:0] div_cnt;
    logic             tick;
    logic             nxt_up;
    logic             nxt_dn;

    assign tick = armed && (div_cnt == DIV_TOP);

    // Reference divider: starts on the arming rise and wraps every TARGET_COUNT clocks.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)       div_cnt <= '0;
        else if (rise && !armed)  div_cnt <= DIV_ONE;
        else if (armed)           div_cnt <= tick ? DIV_ONE : div_cnt + DIV_ONE;
    end

    // Set up on a tick, down on an FG rise, and clear both when the pair completes.
    always_comb begin
        nxt_up = ph_up || tick;
        nxt_dn = ph_dn || (rise && armed);
        if (nxt_up && nxt_dn) begin
            nxt_up = 1'b0;
            nxt_dn = 1'b0;
        end
    end

    // Hold the comparator state.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ph_up <= 1'b0;
            ph_dn <= 1'b0;
        end else begin
            ph_up <= nxt_up;
            ph_dn <= nxt_dn;
        end
    end

    // Both directions are never requested at once.
    p_updn_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ph_up && ph_dn));

    // The divider never runs past its wrap point.
    p_div_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (div_cnt <= DIV_TOP));

    // A down pulse can only begin on an FG rise.
    p_dn_from_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ph_dn && !rise) |=> !ph_dn);

endmodule

// File: rtl/fg_speed_discriminator.sv
// Module: top of the FG period speed discriminator.
// Assumes: fg is synchronised to clk; TARGET_COUNT is a power of two or at
// least even, and the tolerance is one sixteenth of it.
module fg_speed_discriminator #(
    parameter int TARGET_COUNT = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fg,
    output logic accel,
    output logic ph_up,
    output logic ph_dn,
    output logic lock_n
);
    localparam int CNT_W    = $clog2(2 * TARGET_COUNT);
    localparam int LOCK_TOL = TARGET_COUNT / 16;

    logic             fg_rise;
    logic             armed;
    logic             meas_valid;
    logic [CNT_W-1:0] meas_val;

    fsd_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .fg   (fg),
        .rise (fg_rise)
    );

    fsd_period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .rise      (fg_rise),
        .armed     (armed),
        .meas_valid(meas_valid),
        .meas_val  (meas_val)
    );

    fsd_speed_judge #(
        .CNT_W       (CNT_W),
        .TARGET_COUNT(TARGET_COUNT),
        .LOCK_TOL    (LOCK_TOL)
    ) u_judge (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .meas_valid(meas_valid),
        .meas_val  (meas_val),
        .accel     (accel),
        .lock_n    (lock_n)
    );

    fsd_phase_cmp #(
        .CNT_W       (CNT_W),
        .TARGET_COUNT(TARGET_COUNT)
    ) u_phase (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .rise (fg_rise),
        .armed(armed),
        .ph_up(ph_up),
        .ph_dn(ph_dn)
    );

endmodule

// File: tb/sim_fg_speed_discriminator.sv
`timescale 1ns/1ps
module sim_fg_speed_discriminator;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic fg = 1'b0;
    logic accel, ph_up, ph_dn, lock_n;

    int errors = 0;
    int checks = 0;
    int both_seen = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fg_speed_discriminator u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .fg(fg),
        .accel(accel), .ph_up(ph_up), .ph_dn(ph_dn), .lock_n(lock_n)
    );

    // Vectors: period, expected accel, expected lock_n.
    localparam int NV = 8;
    localparam int VP [NV] = '{512, 513, 479, 480, 544, 545, 600, 400};
    localparam bit VA [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
    localparam bit VL [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Entered at the falling edge after a rise. The next rise is sampled p edges later.
    // Samples are counted at falling edges 0..p-1 after the previous rise.
    task automatic period(input int p, output int ups, output int dns);
        ups = 0;
        dns = 0;
        fg = 1'b0;
        for (int j = 0; j < p; j++) begin
            if (j > 0) @(negedge clk);
            if (ph_up) ups++;
            if (ph_dn) dns++;
            if (ph_up && ph_dn) both_seen++;
        end
        fg = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Stop, check the stopped state (R6), restart and arm with one FG rise.
    task automatic restart_arm();
        @(negedge clk);
        run = 1'b0;
        fg = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R6", "lock_n while stopped", int'(lock_n), 1);
        check("R6", "accel while stopped", int'(accel), 1);
        run = 1'b1;
        fg = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            report();
            $finish;
        end
    end

    initial begin
        int u, d, p;
        // R4: reset state
        repeat (3) @(negedge clk);
        check("R4", "accel in reset", int'(accel), 1);
        check("R4", "lock_n in reset", int'(lock_n), 1);
        check("R4", "ph_up in reset", int'(ph_up), 0);
        check("R4", "ph_dn in reset", int'(ph_dn), 0);
        rst_n = 1'b1;

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            p = VP[v];
            restart_arm();
            period(p, u, d);
            // R1: first closed period is discarded
            check("R1", "accel after discarded period", int'(accel), 1);
            check("R1", "lock_n after discarded period", int'(lock_n), 1);
            // R7: slow period gives an up pulse of p-512
            check("R7", "ph_up width", u, (p > 512) ? p - 512 : 0);
            period(p, u, d);
            // R7: fast period gives a down pulse of 512-p, seen in the following period
            check("R7", "ph_dn width", d, (p < 512) ? 512 - p : 0);
            // R2, R3: measured period result
            check("R2", "accel after measured period", int'(accel), int'(VA[v]));
            check("R3", "lock_n after measured period", int'(lock_n), int'(VL[v]));
            // R1: skipped period with an opposite speed has no effect
            period((p < 512) ? 600 : 400, u, d);
            check("R1", "accel after skipped period", int'(accel), int'(VA[v]));
            check("R1", "lock_n after skipped period", int'(lock_n), int'(VL[v]));
        end

        // R5: stall boundary after a locked measurement
        restart_arm();
        period(512, u, d);
        period(512, u, d);
        check("R3", "locked at 512", int'(lock_n), 0);
        fg = 1'b0;
        repeat (1021) @(negedge clk);
        check("R5", "lock_n one clock before saturation", int'(lock_n), 0);
        check("R5", "accel one clock before saturation", int'(accel), 0);
        @(negedge clk);
        check("R5", "lock_n at saturation", int'(lock_n), 1);
        check("R5", "accel at saturation", int'(accel), 1);

        // R6: phase outputs clear while stopped
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        check("R6", "ph_up while stopped", int'(ph_up), 0);
        check("R6", "ph_dn while stopped", int'(ph_dn), 0);

        // R8: never both phase outputs at once in any sampled cycle
        check("R8", "cycles with up and down together", both_seen, 0);

        done = 1'b1;
        report();
        $finish;
    end

endmodule